// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the strobes and the address/data multiplexing of an 8-bit microcontroller's external memory bus over a 16-bit address space. Time is counted in oscillator clocks inside a 12-clock machine cycle. Each machine cycle holds two 6-clock slots. An address-latch strobe (`ale`) opens every slot. A low byte travels on port 0, where it is time-shared with data. A high byte sits on port 2.

At the end of every machine cycle the block takes one request for the next cycle. The request is one of the following:
- an instruction fetch of two bytes at the program counter and the counter plus one;
- a data read or a data write through a 16-bit pointer;
- a data read or a data write through an 8-bit register address;
- no request, which gives an idle cycle.

A strap input chooses where fetches come from. With the strap low, every fetch goes to the bus. With the strap high, a fetch slot goes to the bus only when its address lies above 0FFFH. Otherwise the slot is served internally and makes no bus activity. A control input can silence the address-latch strobe in fetch and idle cycles. Data cycles keep their strobe whatever that input says. Bytes read from the bus come back on `rbyte` with a one-clock valid pulse.

Top module: `mxb_bus_seq`

## Requirements
- R1: A machine cycle is 12 clocks, phases 0 to 11 after reset release. In fetch and idle cycles with `ale_off`=0, `ale` is high for exactly 2 clocks at phases 0-1 and again at phases 6-7, which is one pulse every 6 clocks.
- R2: With `ale_off`=1 sampled for a fetch or idle cycle, `ale` stays low for the whole cycle.
- R3: A data cycle (read or write) raises `ale` only at phases 0-1. Phases 6-7 stay low, so that pulse is skipped. This holds even when `ale_off`=1.
- R4: A bus fetch slot drives `psen_n` low for 3 clocks, starting 1 clock after `ale` falls. That is phases 3-5 for slot 0 and phases 9-11 for slot 1. Data cycles never drive `psen_n` low, so both of its pulses are skipped.
- R5: Slot 0 uses address `fetch_pc` and slot 1 uses `fetch_pc`+1, modulo 2^16. With `ext_strap`=0 both slots go to the bus. With `ext_strap`=1 a slot goes to the bus only when its address is above 0x0FFF. An internal slot keeps `psen_n` high and `p0_oe` low, and `p2_out` equals `p2_latch`.
- R6: A data read drives `rd_n` low, and a data write drives `wr_n` low, for 6 clocks at phases 5-10. This begins 3 clocks after `ale` falls. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R7: On a bus fetch slot, and in slot 0 of a data cycle, `p0_oe`=1 and `p0_out` carries the low address byte for slot phases 0-2. That is 1 clock past the fall of `ale`. After that port 0 is released. `p0_oe` is 0 whenever `psen_n` or `rd_n` is low.
- R8: In a write cycle `p0_out` carries `wr_byte` with `p0_oe`=1 from phase 3 to phase 11, which covers the whole `wr_n` low pulse.
- R9: A bus fetch slot and a 16-bit pointer access (`data_wide`=1) put the high address byte on `p2_out`. An 8-bit register access (`data_wide`=0, address = {8'h00, `data_reg`}) and idle cycles keep `p2_out` equal to `p2_latch`.
- R10: `p0_in` is sampled at the clock edge that ends the last low clock of `psen_n` or `rd_n`. The byte then appears on `rbyte`, with `rbyte_valid` high for one clock, in the following clock. `rbyte_code` is 1 for an instruction byte and 0 for a data byte.
- R11: `cyc_accept` is high in phase 11. The request inputs are sampled at the edge that ends that phase. `data_req` has priority over `fetch_req`, and no request gives an idle cycle.
- R12: Reset is synchronous and active low. While it is held, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0 and `rbyte_valid`=0. The first cycle after release is idle with `ale` silenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Request an instruction fetch cycle |
| fetch_pc | input | 16 | Program counter for fetch slot 0 |
| data_req | input | 1 | Request a data cycle |
| data_we | input | 1 | 1 = data write, 0 = data read |
| data_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit register address |
| data_ptr | input | 16 | 16-bit data pointer |
| data_reg | input | 8 | 8-bit register address |
| wr_byte | input | 8 | Byte to write |
| ext_strap | input | 1 | External-access strap, 0 = all fetches external |
| ale_off | input | 1 | Silence `ale` in fetch and idle cycles |
| p2_latch | input | 8 | Port 2 latch contents |
| p0_in | input | 8 | Port 0 pad input |
| cyc_accept | output | 1 | Last phase of the cycle; requests sampled at its end |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 output byte |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | 8 | Port 2 output byte |
| rbyte | output | 8 | Byte read from the bus |
| rbyte_valid | output | 1 | One-clock valid for `rbyte` |
| rbyte_code | output | 1 | 1 = instruction byte, 0 = data byte |

## Verification
The hardest case to reach is a fetch whose two slots fall on opposite sides of the internal boundary. Here one slot is silent and the other drives `psen_n`. A slot-1 capture then arrives in phase 0 of the next machine cycle, after the next request has already been taken. Directed cycles put `fetch_pc` at 0FFFH and FFFFH with the strap high, so the split goes both ways, including the wrap to 0000H. Random cycles also bias the program counter around the boundary and mix in data cycles with `ale_off` set.

// File: rtl/mxb_pkg.sv
// Shared timing constants and the cycle kind for the external bus sequencer.
// Assumes one machine cycle = MC_CLKS oscillator clocks split in two equal slots.
package mxb_pkg;
    localparam int MC_CLKS    = 12;
    localparam int SLOTS      = 2;
    localparam int PH_W       = $clog2(MC_CLKS);
    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [1:0] {
        CK_IDLE  = 2'd0,
        CK_FETCH = 2'd1,
        CK_DRD   = 2'd2,
        CK_DWR   = 2'd3
    } cyc_kind_e;

    // strobe timing in oscillator clocks
    localparam int ALE_HI    = 2;
    localparam int ADDR_HOLD = 1;
    localparam int PSEN_GAP  = 1;
    localparam int PSEN_LEN  = 3;
    localparam int RW_GAP    = 3;
    localparam int RW_LEN    = 6;

    localparam phase_t SLOT_CLKS  = phase_t'(MC_CLKS / SLOTS);
    localparam phase_t LAST_PH    = phase_t'(MC_CLKS - 1);
    localparam phase_t ALE_END    = phase_t'(ALE_HI);
    localparam phase_t ADDR_LAST  = phase_t'(ALE_HI + ADDR_HOLD - 1);
    localparam phase_t PSEN_FIRST = phase_t'(ALE_HI + PSEN_GAP);
    localparam phase_t PSEN_LAST  = phase_t'(ALE_HI + PSEN_GAP + PSEN_LEN - 1);
    localparam phase_t RW_FIRST   = phase_t'(ALE_HI + RW_GAP);
    localparam phase_t RW_LAST    = phase_t'(ALE_HI + RW_GAP + RW_LEN - 1);
endpackage

// File: rtl/mxb_phase_ctr.sv
// Oscillator-clock phase counter inside one machine cycle.
// Assumes the cycle length is fixed by the package; wraps at LAST_PH.
module mxb_phase_ctr
    import mxb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   cyc_last
);
    // count phases, restart every machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                phase <= '0;
        else if (phase == LAST_PH) phase <= '0;
        else                       phase <= phase + phase_t'(1);
    end

    // last phase marks the request sampling edge
    always_comb cyc_last = (phase == LAST_PH);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_last |=> (phase == '0)); // R1
endmodule

// File: rtl/mxb_cycle_latch.sv
// Captures the request for the next machine cycle at the end of the current one.
// Assumes data requests win over fetches; fetch slots are classified internal
// or external from the strap and the INT_TOP boundary at capture time.
module mxb_cycle_latch
    import mxb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] INT_TOP = 'h0FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_last,
    input  logic             fetch_req,
    input  logic [AW-1:0]    fetch_pc,
    input  logic             data_req,
    input  logic             data_we,
    input  logic             data_wide,
    input  logic [AW-1:0]    data_ptr,
    input  logic [DW-1:0]    data_reg,
    input  logic [DW-1:0]    wr_byte,
    input  logic             ext_strap,
    input  logic             ale_off,
    output cyc_kind_e        kind,
    output logic             ale_off_q,
    output logic [AW-1:0]    addr_q,
    output logic             wide_q,
    output logic [DW-1:0]    wdata_q,
    output logic [SLOTS-1:0] ext_q
);
    logic [AW-1:0]    slot_pc [SLOTS];
    logic [SLOTS-1:0] slot_ext;
    cyc_kind_e        kind_d;
    logic [AW-1:0]    addr_d;

    // per-slot fetch address and bus/internal decision
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_pc[s]  = fetch_pc + AW'(s);
        assign slot_ext[s] = !ext_strap || (slot_pc[s] > INT_TOP);
    end

    // choose next cycle kind and its base address
    always_comb begin
        if (data_req) begin
            kind_d = data_we ? CK_DWR : CK_DRD;
            addr_d = data_wide ? data_ptr : {{(AW-DW){1'b0}}, data_reg};
        end else if (fetch_req) begin
            kind_d = CK_FETCH;
            addr_d = fetch_pc;
        end else begin
            kind_d = CK_IDLE;
            addr_d = '0;
        end
    end

    // hold the cycle descriptor for one machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind      <= CK_IDLE;
            ale_off_q <= 1'b1;
            addr_q    <= '0;
            wide_q    <= 1'b0;
            wdata_q   <= '0;
            ext_q     <= '0;
        end else if (cyc_last) begin
            kind      <= kind_d;
            ale_off_q <= ale_off;
            addr_q    <= addr_d;
            wide_q    <= data_wide;
            wdata_q   <= wr_byte;
            ext_q     <= (kind_d == CK_FETCH) ? slot_ext : '0;
        end
    end

    AST_DATA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_last && data_req) |=> (kind == CK_DRD || kind == CK_DWR)); // R11
endmodule

// File: rtl/mxb_strobe_dec.sv
// Decodes the bus strobes and port-0 drive windows from phase and cycle kind.
// Assumes registered phase and descriptor, so outputs change only after edges.
module mxb_strobe_dec
    import mxb_pkg::*;
#(
    parameter int SL = SLOTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  cyc_kind_e     kind,
    input  logic          ale_off_q,
    input  logic [SL-1:0] ext_q,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          slot,
    output logic          drive_addr,
    output logic          drive_wdata,
    output logic          cap_now,
    output logic          cap_code
);
    phase_t sub;
    logic   is_data;
    logic   fetch_ext;
    logic   rw_win;

    // split the cycle into slot index and phase within slot
    always_comb begin
        slot = (phase >= SLOT_CLKS);
        sub  = slot ? (phase - SLOT_CLKS) : phase;
    end

    // classify the current slot
    always_comb begin
        is_data   = (kind == CK_DRD) || (kind == CK_DWR);
        fetch_ext = (kind == CK_FETCH) && ext_q[slot];
        rw_win    = (phase >= RW_FIRST) && (phase <= RW_LAST);
    end

    // address latch strobe: data cycles skip slot 1, others obey ale_off
    always_comb begin
        if (sub >= ALE_END) ale = 1'b0;
        else if (is_data)   ale = !slot;
        else                ale = !ale_off_q;
    end

    // read/write strobes
    always_comb begin
        psen_n = !(fetch_ext && (sub >= PSEN_FIRST) && (sub <= PSEN_LAST));
        rd_n   = !((kind == CK_DRD) && rw_win);
        wr_n   = !((kind == CK_DWR) && rw_win);
    end

    // port 0 drive windows and read capture points
    always_comb begin
        drive_addr  = (fetch_ext || (is_data && !slot)) && (sub <= ADDR_LAST);
        drive_wdata = (kind == CK_DWR) && (phase > ADDR_LAST);
        cap_now     = (fetch_ext && (sub == PSEN_LAST))
                   || ((kind == CK_DRD) && (phase == RW_LAST));
        cap_code    = (kind == CK_FETCH);
    end

    AST_ALE_TWO_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> ($past(ale, 2) && !$past(ale, 3))); // R1
    AST_PSEN_THREE_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psen_n) |-> (!$past(psen_n, 3) && $past(psen_n, 4))); // R4
    AST_RD_SIX_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7))); // R6
    AST_WR_SIX_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (!$past(wr_n, 6) && $past(wr_n, 7))); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R6
    AST_DATA_NO_PSEN: assert property (@(posedge clk) disable iff (!rst_n)
        is_data |-> psen_n); // R4
endmodule

// File: rtl/mxb_port_mux.sv
// Port 0 and port 2 output multiplexing plus the read-byte capture register.
// Assumes slot 1 of a fetch addresses the base address plus one.
module mxb_port_mux
    import mxb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SL = SLOTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_kind_e     kind,
    input  logic          slot,
    input  logic          drive_addr,
    input  logic          drive_wdata,
    input  logic          cap_now,
    input  logic          cap_code,
    input  logic [AW-1:0] addr_q,
    input  logic          wide_q,
    input  logic [DW-1:0] wdata_q,
    input  logic [SL-1:0] ext_q,
    input  logic [DW-1:0] p2_latch,
    input  logic [DW-1:0] p0_in,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [DW-1:0] p2_out,
    output logic [DW-1:0] rbyte,
    output logic          rbyte_valid,
    output logic          rbyte_code
);
    logic [AW-1:0] slot_addr;

    // address of the current slot (fetch slot 1 is one higher)
    always_comb slot_addr = addr_q + ((kind == CK_FETCH && slot) ? AW'(1) : AW'(0));

    // port 0: low address, then write data, otherwise released
    always_comb begin
        p0_oe = drive_addr || drive_wdata;
        if (drive_addr)       p0_out = slot_addr[DW-1:0];
        else if (drive_wdata) p0_out = wdata_q;
        else                  p0_out = '0;
    end

    // port 2: high address on bus fetch slots and wide pointers, else latch
    always_comb begin
        if (kind == CK_FETCH && ext_q[slot])
            p2_out = slot_addr[AW-1:AW-DW];
        else if ((kind == CK_DRD || kind == CK_DWR) && wide_q)
            p2_out = addr_q[AW-1:AW-DW];
        else
            p2_out = p2_latch;
    end

    // capture the pad byte at the edge ending the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte_valid <= 1'b0;
            rbyte       <= '0;
            rbyte_code  <= 1'b0;
        end else begin
            rbyte_valid <= cap_now;
            if (cap_now) begin
                rbyte      <= p0_in;
                rbyte_code <= cap_code;
            end
        end
    end

    AST_CAPTURE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rbyte_valid |=> !rbyte_valid); // R10
endmodule

// File: rtl/mxb_bus_seq.sv
// Top of the multiplexed external memory bus sequencer.
// Assumes one request per machine cycle, sampled while cyc_accept is high.
module mxb_bus_seq
    import mxb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] INT_TOP = 'h0FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_pc,
    input  logic          data_req,
    input  logic          data_we,
    input  logic          data_wide,
    input  logic [AW-1:0] data_ptr,
    input  logic [DW-1:0] data_reg,
    input  logic [DW-1:0] wr_byte,
    input  logic          ext_strap,
    input  logic          ale_off,
    input  logic [DW-1:0] p2_latch,
    input  logic [DW-1:0] p0_in,
    output logic          cyc_accept,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [DW-1:0] p2_out,
    output logic [DW-1:0] rbyte,
    output logic          rbyte_valid,
    output logic          rbyte_code
);
    phase_t           phase;
    cyc_kind_e        kind;
    logic             ale_off_q;
    logic [AW-1:0]    addr_q;
    logic             wide_q;
    logic [DW-1:0]    wdata_q;
    logic [SLOTS-1:0] ext_q;
    logic             slot, drive_addr, drive_wdata, cap_now, cap_code;

    mxb_phase_ctr i_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cyc_last(cyc_accept)
    );

    mxb_cycle_latch #(.AW(AW), .DW(DW), .INT_TOP(INT_TOP)) i_latch (
        .clk(clk), .rst_n(rst_n), .cyc_last(cyc_accept),
        .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .data_req(data_req), .data_we(data_we), .data_wide(data_wide),
        .data_ptr(data_ptr), .data_reg(data_reg), .wr_byte(wr_byte),
        .ext_strap(ext_strap), .ale_off(ale_off),
        .kind(kind), .ale_off_q(ale_off_q), .addr_q(addr_q),
        .wide_q(wide_q), .wdata_q(wdata_q), .ext_q(ext_q)
    );

    mxb_strobe_dec #(.SL(SLOTS)) i_strobe (
        .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind),
        .ale_off_q(ale_off_q), .ext_q(ext_q),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .slot(slot), .drive_addr(drive_addr), .drive_wdata(drive_wdata),
        .cap_now(cap_now), .cap_code(cap_code)
    );

    mxb_port_mux #(.AW(AW), .DW(DW), .SL(SLOTS)) i_ports (
        .clk(clk), .rst_n(rst_n), .kind(kind), .slot(slot),
        .drive_addr(drive_addr), .drive_wdata(drive_wdata),
        .cap_now(cap_now), .cap_code(cap_code),
        .addr_q(addr_q), .wide_q(wide_q), .wdata_q(wdata_q), .ext_q(ext_q),
        .p2_latch(p2_latch), .p0_in(p0_in),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .rbyte(rbyte), .rbyte_valid(rbyte_valid), .rbyte_code(rbyte_code)
    );

    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !p0_oe); // R7
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> p0_oe); // R8
endmodule

// File: tb/test_mxb_bus_seq.sv
module test_mxb_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_req, data_req, data_we, data_wide, ext_strap, ale_off;
    logic [15:0] fetch_pc, data_ptr;
    logic [7:0]  data_reg, wr_byte, p2_latch, p0_in;
    logic        cyc_accept, ale, psen_n, rd_n, wr_n, p0_oe, rbyte_valid, rbyte_code;
    logic [7:0]  p0_out, p2_out, rbyte;

    always #5 clk = ~clk;

    mxb_bus_seq i_mxb_bus_seq (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .data_req(data_req), .data_we(data_we), .data_wide(data_wide),
        .data_ptr(data_ptr), .data_reg(data_reg), .wr_byte(wr_byte),
        .ext_strap(ext_strap), .ale_off(ale_off), .p2_latch(p2_latch), .p0_in(p0_in),
        .cyc_accept(cyc_accept), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .rbyte(rbyte), .rbyte_valid(rbyte_valid), .rbyte_code(rbyte_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench model of the current machine cycle
    int          m_kind;   // 0 idle, 1 fetch, 2 read, 3 write
    bit          m_aleoff, m_wide, m_both;
    bit          m_ext [2];
    logic [15:0] m_addr;
    logic [7:0]  m_wdata, m_p0;
    bit          pend_v;
    logic [7:0]  pend_b;

    task automatic chk(input string tag, input string what, input int ph,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s phase %0d: got %0h expected %0h", tag, what, ph, act, exp);
        end
    endtask

    // expected outputs at one phase, from the requirements
    task automatic check_phase(input int ph);
        int          sub, sl;
        bit          is_data, fext, bus_slot, oe_e, rv_e;
        logic [15:0] sa;
        logic [7:0]  p0_e, p2_e, rb_e;
        bit          rc_e;
        string       tag;
        sub = ph % 6; sl = ph / 6;
        is_data  = (m_kind >= 2);
        fext     = (m_kind == 1) && m_ext[sl];
        bus_slot = fext || (is_data && sl == 0);
        sa       = (m_kind == 1) ? m_addr + 16'(sl) : m_addr;
        // ale R1 / R2 / R3
        if (is_data) chk("R3", "ale", ph, 32'(ale), 32'(ph < 2));
        else if (m_aleoff) chk("R2", "ale", ph, 32'(ale), 32'(0));
        else chk("R1", "ale", ph, 32'(ale), 32'(sub < 2));
        // psen R4 / R5
        tag = (m_kind == 1 && !m_ext[sl]) ? "R5" : "R4";
        chk(tag, "psen_n", ph, 32'(psen_n), 32'(!(fext && sub >= 3 && sub <= 5)));
        // rd / wr R6, R11 when both requests were raised
        tag = m_both ? "R11" : "R6";
        chk(tag, "rd_n", ph, 32'(rd_n), 32'(!(m_kind == 2 && ph >= 5 && ph <= 10)));
        chk(tag, "wr_n", ph, 32'(wr_n), 32'(!(m_kind == 3 && ph >= 5 && ph <= 10)));
        // port 0 R7 / R8
        oe_e = (bus_slot && sub <= 2) || (m_kind == 3 && ph >= 3);
        chk("R7", "p0_oe", ph, 32'(p0_oe), 32'(oe_e));
        if (bus_slot && sub <= 2) begin
            p0_e = sa[7:0];
            chk("R7", "p0_out addr", ph, 32'(p0_out), 32'(p0_e));
        end else if (m_kind == 3 && ph >= 3) begin
            chk("R8", "p0_out wdata", ph, 32'(p0_out), 32'(m_wdata));
        end
        // port 2 R9
        if (fext) p2_e = sa[15:8];
        else if (is_data && m_wide) p2_e = m_addr[15:8];
        else p2_e = p2_latch;
        chk("R9", "p2_out", ph, 32'(p2_out), 32'(p2_e));
        // accept R11
        chk("R11", "cyc_accept", ph, 32'(cyc_accept), 32'(ph == 11));
        // read capture R10
        rv_e = 1'b0; rb_e = '0; rc_e = 1'b0;
        if (ph == 0 && pend_v) begin rv_e = 1'b1; rb_e = pend_b; rc_e = 1'b1; end
        if (ph == 6 && m_kind == 1 && m_ext[0]) begin rv_e = 1'b1; rb_e = m_p0; rc_e = 1'b1; end
        if (ph == 11 && m_kind == 2) begin rv_e = 1'b1; rb_e = m_p0; rc_e = 1'b0; end
        chk("R10", "rbyte_valid", ph, 32'(rbyte_valid), 32'(rv_e));
        if (rv_e) begin
            chk("R10", "rbyte", ph, 32'(rbyte), 32'(rb_e));
            chk("R10", "rbyte_code", ph, 32'(rbyte_code), 32'(rc_e));
        end
    endtask

    task automatic set_req(input int k, input logic [15:0] a, input bit wide,
                           input bit strap, input bit aoff, input bit both);
        fetch_req = (k == 1) || both;
        data_req  = (k >= 2);
        data_we   = (k == 3);
        data_wide = wide;
        fetch_pc  = a;
        data_ptr  = a;
        data_reg  = a[7:0] ^ 8'h5A;
        wr_byte   = 8'($urandom);
        ext_strap = strap;
        ale_off   = aoff;
        p2_latch  = 8'($urandom);
    endtask

    // directed corner cases first, then random requests
    task automatic pick_next(input int idx);
        int          k;
        logic [15:0] a;
        case (idx)
            0: set_req(1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0); // all external, R5
            1: set_req(1, 16'h0FFF, 1'b0, 1'b1, 1'b0, 1'b0); // split int/ext, R5
            2: set_req(1, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0); // both internal
            3: set_req(1, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0); // wrap to 0000
            4: set_req(2, 16'hA5C3, 1'b1, 1'b0, 1'b1, 1'b0); // R3 with ale_off
            5: set_req(3, 16'h007E, 1'b0, 1'b0, 1'b0, 1'b0); // narrow write, R9
            6: set_req(1, 16'h2000, 1'b0, 1'b0, 1'b1, 1'b0); // R2 fetch
            7: set_req(0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0); // idle
            8: set_req(2, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b1); // R11 priority
            9: set_req(3, 16'hBEEF, 1'b1, 1'b0, 1'b1, 1'b1); // wide write, priority
            default: begin
                k = $urandom_range(0, 3);
                a = ($urandom_range(0, 2) == 0) ? 16'h0FF0 + 16'($urandom_range(0, 31))
                                                : 16'($urandom);
                set_req(k, a, 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
                        (k >= 2) && 1'($urandom));
            end
        endcase
    endtask

    task automatic load_model();
        m_aleoff = ale_off;
        m_both   = data_req && fetch_req;
        m_ext[0] = 1'b0; m_ext[1] = 1'b0;
        m_wide   = data_wide;
        m_wdata  = wr_byte;
        if (data_req) begin
            m_kind = data_we ? 3 : 2;
            m_addr = data_wide ? data_ptr : {8'h00, data_reg};
        end else if (fetch_req) begin
            m_kind   = 1;
            m_addr   = fetch_pc;
            m_ext[0] = !ext_strap || (fetch_pc > 16'h0FFF);
            m_ext[1] = !ext_strap || (16'(fetch_pc + 16'd1) > 16'h0FFF);
        end else begin
            m_kind = 0;
            m_addr = '0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        set_req(0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        p0_in = 8'h00;
        repeat (3) @(negedge clk);
        // reset state R12
        chk("R12", "ale in reset", 0, 32'(ale), 32'(0));
        chk("R12", "psen_n in reset", 0, 32'(psen_n), 32'(1));
        chk("R12", "rd_n in reset", 0, 32'(rd_n), 32'(1));
        chk("R12", "wr_n in reset", 0, 32'(wr_n), 32'(1));
        chk("R12", "p0_oe in reset", 0, 32'(p0_oe), 32'(0));
        chk("R12", "rbyte_valid in reset", 0, 32'(rbyte_valid), 32'(0));
        rst_n = 1'b1;
        #1;
        m_kind = 0; m_aleoff = 1'b1; m_both = 1'b0; m_wide = 1'b0;
        m_ext[0] = 1'b0; m_ext[1] = 1'b0; m_addr = '0; m_wdata = '0;
        m_p0 = 8'h00; pend_v = 1'b0; pend_b = '0;
        for (int cyc = 0; cyc < 260; cyc++) begin
            for (int ph = 0; ph < 12; ph++) begin
                if (ph == 0 && cyc > 0) begin
                    pend_v = (m_kind == 1) && m_ext[1];
                    pend_b = m_p0;
                    load_model();
                end
                check_phase(ph);
                if (ph == 0) begin
                    m_p0  = 8'($urandom);
                    p0_in = m_p0;
                end
                if (ph == 11) pick_next(cyc);
                @(posedge clk);
                @(negedge clk);
                #1;
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule